// File: doc/BRIEF.md
# Start-of-Stream Delimiter Detector

This block sits after symbol alignment in a 100 Mb/s receive path. It takes one aligned 5-bit code group per clock, finds the two-symbol start-of-stream delimiter, and turns the code groups that follow into 4-bit nibbles. It drives a data-valid flag, an error flag and the nibble toward an MII-style receive interface. It also recognises the end-of-stream delimiter pair, idle, and code groups that are not valid data.

A mode input picks one of two detection modes. In normal mode the receive side stays quiet until both delimiter symbols have arrived. In fast mode valid rises on the first delimiter symbol, so data reaches the MII side one code group earlier. The second symbol is then checked one clock later, and an error is raised if it is wrong. The mode is read only when a delimiter starts, so a frame that is already running keeps the mode it started with.

All three outputs are registered. The output for a code group appears one clock after that code group is presented.

Top module: `rx_delim_detect`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released with idle input (11111), valid, error and nibble are all 0.
- R2: In normal mode (fast input 0), the positions of J (11000) and K (10001) produce valid 0. Valid first rises for the data code group that follows K.
- R3: In fast mode (fast input 1), the output for the J position has valid 1 and nibble 0101. The output for the K position that follows also has valid 1 and nibble 0101. Error is 0 at both positions.
- R4: In fast mode, a code group other than K directly after J produces valid 1, error 1 and nibble 0000 at that position. The next position is back to idle, with valid 0.
- R5: In normal mode, a code group other than K directly after J ends the attempt silently. Valid and error stay 0, and a following data code group is not passed on.
- R6: Inside a frame, each of the 16 data code groups (0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101) produces valid 1, error 0 and its nibble, with one clock of latency.
- R7: A T (01101) followed by R (00111) ends the frame. Valid is 0 at the T position and at the R position, and error stays 0.
- R8: A T followed by anything other than R produces error 1 with valid 0 at that second position, and the block returns to idle.
- R9: Idle (11111) arriving inside a frame, without a T before it, produces valid 1, error 1 and nibble 0000 at that position. Valid is 0 from the next position on.
- R10: A code group inside a frame that is neither data, T nor idle produces valid 1, error 1 and nibble 0000 for that nibble time. The frame then continues.
- R11: The fast input is used only when J arrives while idle. Changing it later in the frame has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_i | input | 5 | Aligned code group, one per clock |
| fast_mode_i | input | 1 | 1 selects fast delimiter detection, 0 selects normal |
| rx_dv_o | output | 1 | Receive data valid |
| rx_er_o | output | 1 | Receive error |
| rx_nib_o | output | 4 | Decoded receive nibble |

## Verification
The in-line properties check the local rules on every cycle. These are the response one clock after J in each mode, the error that follows a J with no K behind it in fast mode, the error on idle inside a frame, and error with valid low occurring only right after a T. Other behaviour can only be shown by the bench's scenarios, because it depends on a whole frame. That includes the nibble value for every data code group, the silent drop of a broken delimiter in normal mode, a frame continuing after an invalid code group, and mode changes that arrive mid-frame and must be ignored.

// File: rtl/rx_delim_pkg.sv
package rx_delim_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    localparam logic [SYM_W-1:0] SYM_J    = 5'b11000;
    localparam logic [SYM_W-1:0] SYM_K    = 5'b10001;
    localparam logic [SYM_W-1:0] SYM_T    = 5'b01101;
    localparam logic [SYM_W-1:0] SYM_R    = 5'b00111;
    localparam logic [SYM_W-1:0] SYM_IDLE = 5'b11111;

    localparam logic [NIB_W-1:0] PREAMBLE_NIB = 4'b0101;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_NORM_J,
        ST_FAST_J,
        ST_DATA,
        ST_GOT_T
    } frame_state_t;

    typedef struct packed {
        logic              is_data;
        logic              is_j;
        logic              is_k;
        logic              is_t;
        logic              is_r;
        logic              is_idle;
        logic [NIB_W-1:0]  nib;
    } sym_class_t;

    typedef struct packed {
        frame_state_t      state;
        logic              dv;
        logic              er;
        logic [NIB_W-1:0]  nib;
    } fsm_regs_t;
endpackage

// File: rtl/rx_sym_decode.sv
module rx_sym_decode
    import rx_delim_pkg::*;
(
    input  logic [SYM_W-1:0] code_i,
    output sym_class_t       cls_o
);
    always_comb begin
        cls_o         = '0;
        cls_o.is_data = 1'b1;
        unique case (code_i)
            5'b11110: cls_o.nib = 4'h0;
            5'b01001: cls_o.nib = 4'h1;
            5'b10100: cls_o.nib = 4'h2;
            5'b10101: cls_o.nib = 4'h3;
            5'b01010: cls_o.nib = 4'h4;
            5'b01011: cls_o.nib = 4'h5;
            5'b01110: cls_o.nib = 4'h6;
            5'b01111: cls_o.nib = 4'h7;
            5'b10010: cls_o.nib = 4'h8;
            5'b10011: cls_o.nib = 4'h9;
            5'b10110: cls_o.nib = 4'hA;
            5'b10111: cls_o.nib = 4'hB;
            5'b11010: cls_o.nib = 4'hC;
            5'b11011: cls_o.nib = 4'hD;
            5'b11100: cls_o.nib = 4'hE;
            5'b11101: cls_o.nib = 4'hF;
            default:  cls_o.is_data = 1'b0;
        endcase
        cls_o.is_j    = (code_i == SYM_J);
        cls_o.is_k    = (code_i == SYM_K);
        cls_o.is_t    = (code_i == SYM_T);
        cls_o.is_r    = (code_i == SYM_R);
        cls_o.is_idle = (code_i == SYM_IDLE);
    end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
    import rx_delim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  sym_class_t       cls_i,
    input  logic             fast_mode_i,
    output logic             dv_o,
    output logic             er_o,
    output logic [NIB_W-1:0] nib_o
);
    fsm_regs_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.dv  = 1'b0;
        r_d.er  = 1'b0;
        r_d.nib = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (cls_i.is_j) begin
                    if (fast_mode_i) begin
                        r_d.state = ST_FAST_J;
                        r_d.dv    = 1'b1;
                        r_d.nib   = PREAMBLE_NIB;
                    end else begin
                        r_d.state = ST_NORM_J;
                    end
                end
            end
            ST_NORM_J: begin
                r_d.state = cls_i.is_k ? ST_DATA : ST_IDLE;
            end
            ST_FAST_J: begin
                r_d.dv = 1'b1;
                if (cls_i.is_k) begin
                    r_d.state = ST_DATA;
                    r_d.nib   = PREAMBLE_NIB;
                end else begin
                    r_d.state = ST_IDLE;
                    r_d.er    = 1'b1;
                end
            end
            ST_DATA: begin
                if (cls_i.is_data) begin
                    r_d.dv  = 1'b1;
                    r_d.nib = cls_i.nib;
                end else if (cls_i.is_t) begin
                    r_d.state = ST_GOT_T;
                end else if (cls_i.is_idle) begin
                    r_d.state = ST_IDLE;
                    r_d.dv    = 1'b1;
                    r_d.er    = 1'b1;
                end else begin
                    r_d.dv = 1'b1;
                    r_d.er = 1'b1;
                end
            end
            ST_GOT_T: begin
                r_d.state = ST_IDLE;
                r_d.er    = !cls_i.is_r;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_IDLE;
            r_q.dv    <= 1'b0;
            r_q.er    <= 1'b0;
            r_q.nib   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign dv_o  = r_q.dv;
    assign er_o  = r_q.er;
    assign nib_o = r_q.nib;

    // R3
    fast_j_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && cls_i.is_j && fast_mode_i)
        |=> (dv_o && !er_o && nib_o == PREAMBLE_NIB));

    // R2
    norm_j_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_IDLE && cls_i.is_j && !fast_mode_i)
        |=> (!dv_o && !er_o));

    // R4
    fast_missing_k_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_FAST_J && !cls_i.is_k) |=> (dv_o && er_o));

    // R9
    early_idle_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_DATA && cls_i.is_idle) |=> (dv_o && er_o ##1 !dv_o));

    // R8
    lone_err_after_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (er_o && !dv_o) |-> $past(r_q.state == ST_GOT_T));
endmodule

// File: rtl/rx_delim_detect.sv
module rx_delim_detect
    import rx_delim_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SYM_W-1:0] code_i,
    input  logic             fast_mode_i,
    output logic             rx_dv_o,
    output logic             rx_er_o,
    output logic [NIB_W-1:0] rx_nib_o
);
    sym_class_t cls;

    rx_sym_decode u_decode (
        .code_i (code_i),
        .cls_o  (cls)
    );

    rx_frame_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cls_i       (cls),
        .fast_mode_i (fast_mode_i),
        .dv_o        (rx_dv_o),
        .er_o        (rx_er_o),
        .nib_o       (rx_nib_o)
    );
endmodule

// File: tb/sim_rx_delim_detect.sv
`timescale 1ns/1ps
module sim_rx_delim_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] code = 5'b11111;
    logic       fast = 1'b0;
    logic       dv, er;
    logic [3:0] nib;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rx_delim_detect u0 (
        .clk (clk), .rst_n (rst_n), .code_i (code), .fast_mode_i (fast),
        .rx_dv_o (dv), .rx_er_o (er), .rx_nib_o (nib)
    );

    // row layout: mode, code[4:0], exp_dv, exp_er, exp_nib[3:0]
    localparam int NV = 36;
    localparam logic [11:0] VEC [0:NV-1] = '{
        12'b0_11111_0_0_0000, 12'b0_11000_0_0_0000, 12'b0_10001_0_0_0000,
        12'b0_01011_1_0_0101, 12'b0_10110_1_0_1010, 12'b0_01101_0_0_0000,
        12'b0_00111_0_0_0000, 12'b0_11111_0_0_0000,
        12'b1_11000_1_0_0101, 12'b1_10001_1_0_0101, 12'b1_10101_1_0_0011,
        12'b1_01101_0_0_0000, 12'b1_00111_0_0_0000,
        12'b1_11000_1_0_0101, 12'b1_11111_1_1_0000, 12'b1_11111_0_0_0000,
        12'b0_11000_0_0_0000, 12'b0_01011_0_0_0000, 12'b0_11111_0_0_0000,
        12'b0_11000_0_0_0000, 12'b0_10001_0_0_0000, 12'b0_11101_1_0_1111,
        12'b0_11111_1_1_0000, 12'b0_11111_0_0_0000,
        12'b1_11000_1_0_0101, 12'b1_10001_1_0_0101, 12'b1_00000_1_1_0000,
        12'b1_11110_1_0_0000, 12'b1_01101_0_0_0000, 12'b1_11111_0_1_0000,
        12'b1_11111_0_0_0000,
        12'b0_11000_0_0_0000, 12'b1_10001_0_0_0000, 12'b1_01001_1_0_0001,
        12'b0_01101_0_0_0000, 12'b0_00111_0_0_0000
    };

    function automatic string req_of(int i);
        if (i == 3 || i == 4)  return "R6";
        if (i == 5 || i == 6)  return "R7";
        if (i < 8)             return "R2";
        if (i < 13)            return "R3";
        if (i < 16)            return "R4";
        if (i < 19)            return "R5";
        if (i < 24)            return "R9";
        if (i == 29)           return "R8";
        if (i < 31)            return "R10";
        return "R11";
    endfunction

    function automatic logic [4:0] enc(int v);
        case (v)
            0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
            4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
            8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
           12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic drive(input logic m, input logic [4:0] c);
        @(negedge clk);
        fast = m;
        code = c;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic edv, input logic eer, input logic [3:0] enib);
        n_chk++;
        if (dv !== edv || er !== eer || nib !== enib) begin
            n_fail++;
            $display("FAIL %s: dv/er/nib = %b/%b/%h, expected %b/%b/%h",
                     req, dv, er, nib, edv, eer, enib);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", 1'b0, 1'b0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 5'b11111);
        chk("R1", 1'b0, 1'b0, 4'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][11], VEC[i][10:6]);
            chk(req_of(i), VEC[i][5], VEC[i][4], VEC[i][3:0]);
        end

        // R6: every data code group inside a fast frame
        drive(1'b1, 5'b11000);
        drive(1'b1, 5'b10001);
        for (int v = 0; v < 16; v++) begin
            drive(1'b1, enc(v));
            chk("R6", 1'b1, 1'b0, 4'(v));
        end
        drive(1'b1, 5'b01101);
        chk("R7", 1'b0, 1'b0, 4'h0);
        drive(1'b1, 5'b00111);
        chk("R7", 1'b0, 1'b0, 4'h0);

        // R1: reset in the middle of a fast frame
        drive(1'b1, 5'b11000);
        drive(1'b1, 5'b10001);
        @(negedge clk);
        rst_n = 1'b0;
        code  = 5'b01011;
        @(posedge clk);
        #1;
        chk("R1", 1'b0, 1'b0, 4'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 5'b01011);
        chk("R1", 1'b0, 1'b0, 4'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule